// File: doc/BRIEF.md
# Multi-Port Cell Transmit Slave

This block sits on the physical-layer side of a shared cell bus and takes in cells that an ATM-layer master sends to it. Four logical ports share one 8-bit data bus. Each port has its own 5-bit bus address, which comes from a configuration input. The master finds out where there is room by driving a port address and reading the space flag one clock later. The flag's output-enable is high only while one of this block's own ports is addressed, which models a tri-state driver.

The master selects a port by driving its address while the active-low enable is high. It then pulls the enable low and streams the bytes of the cell, with a start-of-cell marker on the first byte and an odd parity bit on every byte. The master may raise the enable to pause in the middle of a cell. Each port owns a one-cell buffer inside a single shared byte RAM. A full port reports no space until the consumer frees its buffer with a drain pulse. The consumer reads stored bytes through a registered read port. Two per-port pulses report parity errors and aborted (runt) cells.

Top module: `cbts_tx_slave`

## Requirements
- R1: After a synchronous reset, all ports are empty, `space_oe_o` is 0, `space_o` is 0, and `par_err_o` and `runt_o` are all zero.
- R2: Port p answers to the 5-bit address in `cfg_addr_i[p*5 +: 5]`. When several ports hold the same address, the lowest-numbered port wins.
- R3: When an address is driven in cycle t, then one clock edge later `space_oe_o` is 1 if a port matches, and `space_o` is 1 if that port's buffer has room. When no port matches, both outputs are 0.
- R4: A port's space flag is 0 while its buffer holds an undrained cell. A one-cycle `drain_i[p]` pulse frees the buffer, and the next poll shows space again.
- R5: An address that matches a port while `bus_en_n_i` is 1 selects that port. An address that matches no port leaves the current selection in place.
- R6: A byte is accepted on every clock edge where `bus_en_n_i` is 0 and a port is selected. A byte with `bus_soc_i`=1 is stored at index 0. Each later byte goes to the next index. Bytes without the start marker are dropped when no cell is in progress.
- R7: While `bus_en_n_i` is 1, no byte is stored, counted or parity-checked. The transfer resumes at the next index once the enable returns to 0.
- R8: The 53rd byte of a cell completes it and marks the port full. Bytes sent to a full port are dropped, and its stored bytes stay unchanged.
- R9: A start marker on a cell already in progress raises `runt_o[p]` for one cycle, one edge after the byte. The new cell then starts again at index 0.
- R10: Odd parity: when the XOR of the 8 data bits and `bus_par_i` is 0 on an accepted byte, `par_err_o[p]` of the selected port is 1 for one cycle, one edge later. Otherwise all bits are 0.
- R11: `rd_data_o` holds, one edge after `rd_port_i`/`rd_idx_i` are presented, the byte stored at that index of that port's buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr_i | input | 20 | Bus address of each port, 5 bits per port, port 0 in the low bits |
| bus_addr_i | input | 5 | Poll and select address from the master |
| bus_data_i | input | 8 | Cell byte |
| bus_par_i | input | 1 | Odd parity bit for `bus_data_i` |
| bus_soc_i | input | 1 | Start-of-cell marker on the first byte |
| bus_en_n_i | input | 1 | Active-low transfer enable |
| space_o | output | 1 | Space flag of the addressed port |
| space_oe_o | output | 1 | Output-enable of the space flag |
| drain_i | input | 4 | Per-port pulse that frees the stored cell |
| rd_port_i | input | 2 | Port whose buffer is read |
| rd_idx_i | input | 6 | Byte index within that buffer |
| rd_data_o | output | 8 | Registered read data |
| par_err_o | output | 4 | Per-port parity error pulse |
| runt_o | output | 4 | Per-port aborted-cell pulse |

## Verification
The bench builds the block with its defaults: four ports, 5-bit addresses and 53-byte cells. With these values a whole cell, including the completion on byte 53, fits in a short run. The defaults also allow two ports to be given the same address, so the lowest-index priority can be checked. Directed sequences cover a paused cell, bytes sent to a full port, a runt restart, a bad-parity byte and data bytes that arrive before any start marker. A behavioural model is compared against the outputs on every clock.

// File: rtl/cbts_pkg.sv
package cbts_pkg;
  localparam int unsigned DEF_PORTS      = 4;
  localparam int unsigned DEF_DATA_W     = 8;
  localparam int unsigned DEF_ADDR_W     = 5;
  localparam int unsigned DEF_CELL_BYTES = 53;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cbts_addr_dec.sv
module cbts_addr_dec #(
  parameter int unsigned NP = 4,
  parameter int unsigned AW = 5,
  parameter int unsigned PW = 2
) (
  input  logic [NP*AW-1:0] cfg_i,
  input  logic [AW-1:0]    addr_i,
  output logic             hit_o,
  output logic [PW-1:0]    idx_o
);
  logic [NP-1:0] match;

  for (genvar p = 0; p < NP; p++) begin : g_cmp
    assign match[p] = (cfg_i[p*AW +: AW] == addr_i);
  end

  always_comb begin
    hit_o = |match;
    idx_o = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (match[i]) idx_o = PW'(i);
    end
  end
endmodule

// File: rtl/cbts_port_ctl.sv
module cbts_port_ctl #(
  parameter int unsigned CELL_BYTES = 53,
  parameter int unsigned IW         = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          beat_i,
  input  logic          soc_i,
  input  logic          drain_i,
  output logic          we_o,
  output logic [IW-1:0] widx_o,
  output logic          full_o,
  output logic          runt_o
);
  logic [IW-1:0] idx_q;
  logic          full_q;
  logic          runt_q;
  logic          take;
  logic          started;
  logic          last;

  assign take    = beat_i & ~full_q;
  assign started = (idx_q != '0);
  assign we_o    = take & (soc_i | started);
  assign widx_o  = soc_i ? '0 : idx_q;
  assign last    = we_o & (widx_o == IW'(CELL_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      full_q <= 1'b0;
      runt_q <= 1'b0;
    end else begin
      runt_q <= take & soc_i & started;
      full_q <= (full_q & ~drain_i) | last;
      if (we_o) idx_q <= last ? '0 : widx_o + 1'b1;
    end
  end

  assign full_o = full_q;
  assign runt_o = runt_q;
endmodule

// File: rtl/cbts_cell_ram.sv
module cbts_cell_ram #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 212,
  parameter int unsigned RAW   = 8
) (
  input  logic           clk,
  input  logic           we_i,
  input  logic [RAW-1:0] waddr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [RAW-1:0] raddr_i,
  output logic [DW-1:0]  rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/cbts_tx_slave.sv
module cbts_tx_slave
  import cbts_pkg::*;
#(
  parameter int unsigned NP         = DEF_PORTS,
  parameter int unsigned DW         = DEF_DATA_W,
  parameter int unsigned AW         = DEF_ADDR_W,
  parameter int unsigned CELL_BYTES = DEF_CELL_BYTES,
  localparam int unsigned PW        = idx_width(NP),
  localparam int unsigned IW        = idx_width(CELL_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NP*AW-1:0] cfg_addr_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_data_i,
  input  logic             bus_par_i,
  input  logic             bus_soc_i,
  input  logic             bus_en_n_i,
  output logic             space_o,
  output logic             space_oe_o,
  input  logic [NP-1:0]    drain_i,
  input  logic [PW-1:0]    rd_port_i,
  input  logic [IW-1:0]    rd_idx_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [NP-1:0]    par_err_o,
  output logic [NP-1:0]    runt_o
);
  localparam int unsigned DEPTH = NP * CELL_BYTES;
  localparam int unsigned RAW   = idx_width(DEPTH);

  logic          hit;
  logic [PW-1:0] hit_idx;
  logic [PW-1:0] sel_q;
  logic          selv_q;
  logic          accept;
  logic          bad_par;
  logic [NP-1:0] we_vec;
  logic [NP-1:0] full_vec;
  logic [IW-1:0] widx_arr [NP];
  logic          ram_we;
  logic [RAW-1:0] ram_waddr;
  logic [RAW-1:0] ram_raddr;
  logic          sp_q;
  logic          oe_q;
  logic [NP-1:0] perr_q;

  cbts_addr_dec #(.NP(NP), .AW(AW), .PW(PW)) u_dec (
    .cfg_i  (cfg_addr_i),
    .addr_i (bus_addr_i),
    .hit_o  (hit),
    .idx_o  (hit_idx)
  );

  // selection latch: a matching address with enable high picks the port
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      selv_q <= 1'b0;
    end else if (bus_en_n_i && hit) begin
      sel_q  <= hit_idx;
      selv_q <= 1'b1;
    end
  end

  assign accept  = ~bus_en_n_i & selv_q;
  assign bad_par = ~(^{bus_data_i, bus_par_i});

  for (genvar p = 0; p < NP; p++) begin : g_port
    cbts_port_ctl #(.CELL_BYTES(CELL_BYTES), .IW(IW)) u_ctl (
      .clk     (clk),
      .rst     (rst),
      .beat_i  (accept && (sel_q == PW'(p))),
      .soc_i   (bus_soc_i),
      .drain_i (drain_i[p]),
      .we_o    (we_vec[p]),
      .widx_o  (widx_arr[p]),
      .full_o  (full_vec[p]),
      .runt_o  (runt_o[p])
    );
  end

  always_comb begin
    ram_we    = |we_vec;
    ram_waddr = RAW'(sel_q) * RAW'(CELL_BYTES) + RAW'(widx_arr[sel_q]);
    ram_raddr = RAW'(rd_port_i) * RAW'(CELL_BYTES) + RAW'(rd_idx_i);
  end

  cbts_cell_ram #(.DW(DW), .DEPTH(DEPTH), .RAW(RAW)) u_ram (
    .clk     (clk),
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (bus_data_i),
    .raddr_i (ram_raddr),
    .rdata_o (rd_data_o)
  );

  // poll response and parity flags, registered
  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q   <= 1'b0;
      sp_q   <= 1'b0;
      perr_q <= '0;
    end else begin
      oe_q <= hit;
      sp_q <= hit & ~full_vec[hit_idx];
      for (int p = 0; p < NP; p++) begin
        perr_q[p] <= accept && (sel_q == PW'(p)) && bad_par;
      end
    end
  end

  assign space_o    = sp_q;
  assign space_oe_o = oe_q;
  assign par_err_o  = perr_q;
endmodule

// File: rtl/cbts_tx_chk.sv
module cbts_tx_chk #(
  parameter int unsigned NP = 4,
  parameter int unsigned AW = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [NP*AW-1:0] cfg_addr_i,
  input logic [AW-1:0]    bus_addr_i,
  input logic             bus_soc_i,
  input logic             bus_en_n_i,
  input logic             space_o,
  input logic             space_oe_o,
  input logic [NP-1:0]    par_err_o,
  input logic [NP-1:0]    runt_o
);
  logic any_hit;

  always_comb begin
    any_hit = 1'b0;
    for (int p = 0; p < NP; p++) begin
      if (cfg_addr_i[p*AW +: AW] == bus_addr_i) any_hit = 1'b1;
    end
  end

  p_oe_follows_poll_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (space_oe_o == $past(any_hit)));

  p_space_needs_oe_r4: assert property (@(posedge clk) disable iff (rst)
    space_o |-> space_oe_o);

  p_pause_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_en_n_i)) |-> (par_err_o == '0 && runt_o == '0));

  p_runt_after_soc_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (runt_o != '0)) |-> $past(bus_soc_i));

  p_runt_single_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(runt_o));

  p_perr_single_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(par_err_o));
endmodule

bind cbts_tx_slave cbts_tx_chk #(.NP(NP), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_addr_i (cfg_addr_i),
  .bus_addr_i (bus_addr_i),
  .bus_soc_i  (bus_soc_i),
  .bus_en_n_i (bus_en_n_i),
  .space_o    (space_o),
  .space_oe_o (space_oe_o),
  .par_err_o  (par_err_o),
  .runt_o     (runt_o)
);

// File: tb/test_cbts_tx_slave.sv
module test_cbts_tx_slave;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int CB = 53;
  localparam int PW = 2;
  localparam int IW = 6;
  localparam logic [AW-1:0] NOADDR = 5'd31;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP*AW-1:0] cfg_addr;
  logic [AW-1:0] bus_addr = NOADDR;
  logic [DW-1:0] bus_data = '0;
  logic bus_par = 1'b1;
  logic bus_soc = 1'b0;
  logic bus_en_n = 1'b1;
  logic [NP-1:0] drain = '0;
  logic [PW-1:0] rd_port = '0;
  logic [IW-1:0] rd_idx = '0;
  logic space, space_oe;
  logic [DW-1:0] rd_data;
  logic [NP-1:0] par_err, runt;

  cbts_tx_slave i_cbts_tx_slave (
    .clk(clk), .rst(rst), .cfg_addr_i(cfg_addr), .bus_addr_i(bus_addr),
    .bus_data_i(bus_data), .bus_par_i(bus_par), .bus_soc_i(bus_soc),
    .bus_en_n_i(bus_en_n), .space_o(space), .space_oe_o(space_oe),
    .drain_i(drain), .rd_port_i(rd_port), .rd_idx_i(rd_idx),
    .rd_data_o(rd_data), .par_err_o(par_err), .runt_o(runt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model state
  logic [7:0] m_mem [NP][CB];
  int m_idx [NP];
  bit m_full [NP];
  int m_sel = 0;
  bit m_selv = 1'b0;
  bit e_oe, e_sp;
  logic [NP-1:0] e_par, e_runt;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int find_port(input logic [AW-1:0] a);
    for (int p = 0; p < NP; p++) if (cfg_addr[p*AW +: AW] == a) return p;
    return -1;
  endfunction

  task automatic model_edge();
    int m;
    bit done;
    int s;
    done = 1'b0;
    s = m_sel;
    e_oe = 1'b0; e_sp = 1'b0; e_par = '0; e_runt = '0;
    if (rst) begin
      for (int p = 0; p < NP; p++) begin m_idx[p] = 0; m_full[p] = 1'b0; end
      m_sel = 0; m_selv = 1'b0;
      return;
    end
    m = find_port(bus_addr);
    if (m >= 0) begin e_oe = 1'b1; e_sp = !m_full[m]; end
    if (!bus_en_n && m_selv) begin
      if ((^{bus_data, bus_par}) == 1'b0) e_par[s] = 1'b1;
      if (!m_full[s]) begin
        if (bus_soc) begin
          if (m_idx[s] != 0) e_runt[s] = 1'b1;
          m_mem[s][0] = bus_data;
          m_idx[s] = 1;
        end else if (m_idx[s] != 0) begin
          m_mem[s][m_idx[s]] = bus_data;
          m_idx[s]++;
        end
        if (m_idx[s] == CB) begin done = 1'b1; m_idx[s] = 0; end
      end
    end
    for (int p = 0; p < NP; p++)
      m_full[p] = (m_full[p] && !drain[p]) || (done && p == s);
    if (bus_en_n && m >= 0) begin m_sel = m; m_selv = 1'b1; end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R3 space_oe", int'(space_oe), int'(e_oe));
    chk("R3 space", int'(space), int'(e_sp));
    chk("R10 par_err", int'(par_err), int'(e_par));
    chk("R9 runt", int'(runt), int'(e_runt));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      bus_en_n = 1'b1; bus_addr = NOADDR; bus_soc = 1'b0; drain = '0;
      tick();
    end
  endtask

  task automatic select(input logic [AW-1:0] a);
    bus_en_n = 1'b1; bus_addr = a; bus_soc = 1'b0;
    tick();
  endtask

  task automatic send(input logic [7:0] d, input bit soc, input bit badpar);
    bus_en_n = 1'b0; bus_addr = NOADDR; bus_data = d; bus_soc = soc;
    bus_par = badpar ? (^d) : ~(^d);
    tick();
  endtask

  task automatic poll(input logic [AW-1:0] a, input int exp_oe, input int exp_sp,
                      input string req);
    select(a);
    chk(req, int'(space_oe), exp_oe);
    chk(req, int'(space), exp_sp);
  endtask

  task automatic rd_expect(input int p, input int i, input int exp, input string req);
    bus_en_n = 1'b1; bus_addr = NOADDR; bus_soc = 1'b0;
    rd_port = PW'(p); rd_idx = IW'(i);
    tick();
    chk(req, int'(rd_data), exp);
    chk("R11 model", int'(rd_data), int'(m_mem[p][i]));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cfg_addr = {5'd30, 5'd17, 5'd9, 5'd5};
    idle(3);
    rst = 1'b0;
    idle(1);
    chk("R1 oe after reset", int'(space_oe), 0);
    chk("R1 par_err after reset", int'(par_err), 0);
    chk("R1 runt after reset", int'(runt), 0);

    poll(5'd5, 1, 1, "R1 R3 port0 empty");
    poll(5'd9, 1, 1, "R3 port1");
    poll(5'd17, 1, 1, "R3 port2");
    poll(5'd30, 1, 1, "R3 port3");
    poll(5'd0, 0, 0, "R3 unmatched");

    // full cell to port1 with a pause after byte 20
    select(5'd9);
    for (int k = 0; k < CB; k++) begin
      send(8'(8'h10 + k), k == 0, 1'b0);
      if (k == 20) idle(3);
    end
    idle(1);
    poll(5'd9, 1, 0, "R8 R4 port1 full");
    rd_expect(1, 0, 8'h10, "R6 first byte");
    rd_expect(1, 20, 8'h10 + 20, "R7 before pause");
    rd_expect(1, 21, 8'h10 + 21, "R7 after pause");
    rd_expect(1, 52, 8'h10 + 52, "R8 last byte");

    // bytes to a full port are dropped
    select(5'd9);
    send(8'hEE, 1'b1, 1'b0);
    send(8'hEF, 1'b0, 1'b0);
    chk("R8 no runt on full", int'(runt), 0);
    rd_expect(1, 0, 8'h10, "R8 contents kept");
    rd_expect(1, 1, 8'h11, "R8 contents kept");

    // runt on port2
    select(5'd17);
    for (int k = 0; k < 10; k++) send(8'(8'h40 + k), k == 0, 1'b0);
    send(8'h80, 1'b1, 1'b0);
    chk("R9 runt pulse port2", int'(runt), 4);
    for (int k = 1; k < CB; k++) send(8'(8'h80 + k), 1'b0, 1'b0);
    chk("R9 pulse gone", int'(runt), 0);
    rd_expect(2, 0, 8'h80, "R9 restart at 0");
    rd_expect(2, 10, 8'h8A, "R9 overwritten");
    poll(5'd17, 1, 0, "R9 R8 port2 full");

    // parity on port3
    select(5'd30);
    send(8'h55, 1'b1, 1'b1);
    chk("R10 bad parity port3", int'(par_err), 8);
    send(8'h56, 1'b0, 1'b0);
    chk("R10 good parity", int'(par_err), 0);

    // bytes before a start marker are dropped, selection persists
    select(5'd5);
    send(8'h01, 1'b0, 1'b0);
    send(8'h02, 1'b0, 1'b0);
    send(8'h22, 1'b1, 1'b0);
    send(8'h23, 1'b0, 1'b0);
    idle(4);
    send(8'h24, 1'b0, 1'b0);
    rd_expect(0, 0, 8'h22, "R6 dropped before soc");
    rd_expect(0, 1, 8'h23, "R6 next index");
    rd_expect(0, 2, 8'h24, "R5 selection kept");

    // duplicate address: lowest port wins
    cfg_addr = {5'd30, 5'd17, 5'd9, 5'd9};
    poll(5'd9, 1, 1, "R2 lowest port wins");
    cfg_addr = {5'd30, 5'd17, 5'd9, 5'd5};
    poll(5'd9, 1, 0, "R2 restored port1");

    // drain frees buffers
    bus_en_n = 1'b1; bus_addr = NOADDR; drain = 4'b0110;
    tick();
    drain = '0;
    poll(5'd9, 1, 1, "R4 port1 drained");
    poll(5'd17, 1, 1, "R4 port2 drained");
    idle(2);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule